// File: doc/BRIEF.md
# I2C Master/Slave Control Sequencer

This block holds the control word of an I2C controller that can act either as bus master or as an addressed slave, and it sequences requests for mastership. Software writes a five-bit control word. A bit-level engine reports the bus state: bus busy, transfer direction, addressed as slave, arbitration lost and end of byte. From these the block issues one-cycle start and stop commands to the engine. It also selects the acknowledge value that the engine drives for the byte being received, keeps the interrupt flag that stretches SCL, and raises the interrupt request.

Software asks for mastership by writing master-select as 1. On an idle bus the start-and-address command goes out at once. On a busy bus the request is held until the bus frees. The held request is dropped if the block is meanwhile addressed as a transmitting slave. When arbitration is lost, hardware clears master-select. When software clears master-select while the interrupt flag is set, the block issues a stop, clears the flag and leaves master mode.

Top module: `i2c_ctl_seq`

## Requirements
- R1: The control word has master-select at bit 0, data-acknowledge enable at bit 1, general-call acknowledge enable at bit 2, interrupt enable at bit 3 and the interrupt flag at bit 4. A write replaces the word in the cycle after `wr_en`. Reset sets every output to 0.
- R2: Writing master-select = 1 while not master and while `bus_busy` is low gives `cmd_start` for exactly one cycle, in the cycle after the write. Master-select then reads 1.
- R3: Writing master-select = 1 while `bus_busy` is high and `xmit_dir` is low makes master-select read 1 with no start. The start pulse follows the first cycle in which `bus_busy` is sampled low.
- R4: A held request is dropped, with master-select reading 0 and no start later, when `slave_hit` and `xmit_dir` are both sampled high. Being addressed as a receiving slave (`slave_hit` high, `xmit_dir` low) keeps the request held.
- R5: While master, `arb_lost` clears master-select and sets `arb_lost_flag` in the next cycle. `arb_lost` has no effect when not master. The flag clears on the next software write of master-select = 1 made while not master.
- R6: Writing master-select = 0 while master with the interrupt flag set gives a one-cycle `cmd_stop`, clears master-select and clears the interrupt flag, all in the next cycle. The same write with the flag clear gives no stop.
- R7: `byte_done` sets the interrupt flag when the block is master or when `slave_hit` is high, and leaves it unchanged otherwise. Software writing 0 to bit 4 clears the flag. Writing 1 to bit 4 has no effect. `scl_hold` follows the flag.
- R8: `irq` is high exactly when both the interrupt flag and the interrupt enable are 1.
- R9: `ack_out` depends on `rx_kind`. Code 0 (data byte) gives the data-acknowledge enable. Code 1 (7-bit address) gives `en_addr7`. Code 2 (10-bit address) gives `en_addr10`. Code 3 (general call) gives the general-call acknowledge enable.
- R10: Master-select only becomes 1 through a software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 5 | Control word write value |
| bus_busy | input | 1 | Bus is between a start and a stop |
| xmit_dir | input | 1 | Block is the transmitting side |
| slave_hit | input | 1 | Block is addressed as slave |
| arb_lost | input | 1 | Arbitration lost pulse from engine |
| byte_done | input | 1 | Byte and acknowledge bit finished |
| rx_kind | input | 2 | Kind of byte being received |
| en_addr7 | input | 1 | 7-bit slave address acknowledge enable |
| en_addr10 | input | 1 | 10-bit slave address acknowledge enable |
| ctl_rd | output | 5 | Current control word |
| cmd_start | output | 1 | Start and send address command pulse |
| cmd_stop | output | 1 | Stop command pulse |
| arb_lost_flag | output | 1 | Arbitration lost status |
| ack_out | output | 1 | Acknowledge value for current byte |
| scl_hold | output | 1 | Hold SCL low |
| irq | output | 1 | Interrupt request |

## Verification
Every registered result is due one cycle after the stimulus that causes it. That stimulus is a write or a sampled status input. Such results are start, stop, master-select, the arbitration flag, the interrupt flag and `irq`. `ack_out` is combinational, so it is due in the same cycle as its inputs, and it is therefore settled at the edge that follows. The driver changes inputs on the falling edge and queues each expectation tagged with the number of the next rising edge. The monitor compares a quarter period after that edge, so every output is sampled one register stage after its cause. One-cycle pulses are also checked on the following edge, to confirm that they have fallen again.

// File: rtl/i2c_seq_pkg.sv
`timescale 1ns/1ps
package i2c_seq_pkg;
    localparam int CTL_W  = 5;
    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        RK_DATA   = 2'd0,
        RK_ADDR7  = 2'd1,
        RK_ADDR10 = 2'd2,
        RK_GCALL  = 2'd3
    } rx_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_WAIT   = 2'd1,
        SQ_MASTER = 2'd2
    } sq_state_e;

    typedef struct packed {
        logic int_flag;
        logic irq_en;
        logic gc_ack;
        logic data_ack;
        logic msel;
    } ctl_word_t;

    function automatic logic ack_pick(rx_kind_e k, logic dack, logic gcack,
                                      logic e7, logic e10);
        logic r;
        case (k)
            RK_DATA:   r = dack;
            RK_ADDR7:  r = e7;
            RK_ADDR10: r = e10;
            default:   r = gcack;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/i2c_master_seq.sv
`timescale 1ns/1ps
module i2c_master_seq
    import i2c_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_msel,
    input  logic int_flag,
    input  logic bus_busy,
    input  logic xmit_dir,
    input  logic slave_hit,
    input  logic arb_lost,
    output logic msel,
    output logic cmd_start,
    output logic cmd_stop,
    output logic arb_flag,
    output logic auto_clr
);
    sq_state_e state_q, state_d;
    logic start_d, stop_d, al_d;

    always_comb begin
        state_d = state_q;
        start_d = 1'b0;
        stop_d  = 1'b0;
        al_d    = arb_flag;
        case (state_q)
            SQ_IDLE: begin
                if (wr_en && wr_msel) begin
                    al_d = 1'b0;
                    if (!bus_busy) begin
                        state_d = SQ_MASTER;
                        start_d = 1'b1;
                    end else if (!xmit_dir) begin
                        state_d = SQ_WAIT;
                    end
                end
            end
            SQ_WAIT: begin
                if (wr_en && !wr_msel) begin
                    state_d = SQ_IDLE;
                end else if (slave_hit && xmit_dir) begin
                    state_d = SQ_IDLE;
                end else if (!bus_busy) begin
                    state_d = SQ_MASTER;
                    start_d = 1'b1;
                end
            end
            SQ_MASTER: begin
                if (arb_lost) begin
                    state_d = SQ_IDLE;
                    al_d    = 1'b1;
                end else if (wr_en && !wr_msel) begin
                    state_d = SQ_IDLE;
                    stop_d  = int_flag;
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    assign auto_clr = stop_d;
    assign msel     = (state_q != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SQ_IDLE;
            cmd_start <= 1'b0;
            cmd_stop  <= 1'b0;
            arb_flag  <= 1'b0;
        end else begin
            state_q   <= state_d;
            cmd_start <= start_d;
            cmd_stop  <= stop_d;
            arb_flag  <= al_d;
        end
    end

    AST_MSEL_SW_SET: assert property (@(posedge clk) disable iff (rst)
        $rose(msel) |-> $past(wr_en && wr_msel)); // R10
    AST_START_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> $past(!bus_busy)); // R2
    AST_ARB_DROP: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_MASTER && arb_lost) |=> (!msel && arb_flag)); // R5
    AST_DROP_TX_SLAVE: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_WAIT && !wr_en && slave_hit && xmit_dir) |=> (!msel && !cmd_start)); // R4
endmodule

// File: rtl/i2c_int_unit.sv
`timescale 1ns/1ps
module i2c_int_unit (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_int,
    input  logic auto_clr,
    input  logic byte_done,
    input  logic msel,
    input  logic slave_hit,
    input  logic irq_en,
    output logic int_flag,
    output logic irq
);
    logic int_d;

    always_comb begin
        int_d = int_flag;
        if (auto_clr)
            int_d = 1'b0;
        else if (byte_done && (msel || slave_hit))
            int_d = 1'b1;
        else if (wr_en && !wr_int)
            int_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) int_flag <= 1'b0;
        else     int_flag <= int_d;
    end

    assign irq = int_flag & irq_en;

    AST_INT_SET: assert property (@(posedge clk) disable iff (rst)
        (byte_done && (msel || slave_hit) && !auto_clr) |=> int_flag); // R7
    AST_INT_NO_SW_SET: assert property (@(posedge clk) disable iff (rst)
        $rose(int_flag) |-> $past(byte_done)); // R7
endmodule

// File: rtl/i2c_ctl_seq.sv
`timescale 1ns/1ps
module i2c_ctl_seq
    import i2c_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             bus_busy,
    input  logic             xmit_dir,
    input  logic             slave_hit,
    input  logic             arb_lost,
    input  logic             byte_done,
    input  logic [KIND_W-1:0] rx_kind,
    input  logic             en_addr7,
    input  logic             en_addr10,
    output logic [CTL_W-1:0] ctl_rd,
    output logic             cmd_start,
    output logic             cmd_stop,
    output logic             arb_lost_flag,
    output logic             ack_out,
    output logic             scl_hold,
    output logic             irq
);
    ctl_word_t wr_w;
    ctl_word_t rd_w;
    logic msel, int_flag, auto_clr;
    logic data_ack_q, gc_ack_q, irq_en_q;

    assign wr_w = ctl_word_t'(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_ack_q <= 1'b0;
            gc_ack_q   <= 1'b0;
            irq_en_q   <= 1'b0;
        end else if (wr_en) begin
            data_ack_q <= wr_w.data_ack;
            gc_ack_q   <= wr_w.gc_ack;
            irq_en_q   <= wr_w.irq_en;
        end
    end

    i2c_master_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_msel   (wr_w.msel),
        .int_flag  (int_flag),
        .bus_busy  (bus_busy),
        .xmit_dir  (xmit_dir),
        .slave_hit (slave_hit),
        .arb_lost  (arb_lost),
        .msel      (msel),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .arb_flag  (arb_lost_flag),
        .auto_clr  (auto_clr)
    );

    i2c_int_unit u_int (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_int    (wr_w.int_flag),
        .auto_clr  (auto_clr),
        .byte_done (byte_done),
        .msel      (msel),
        .slave_hit (slave_hit),
        .irq_en    (irq_en_q),
        .int_flag  (int_flag),
        .irq       (irq)
    );

    assign ack_out  = ack_pick(rx_kind_e'(rx_kind), data_ack_q, gc_ack_q,
                               en_addr7, en_addr10);
    assign scl_hold = int_flag;

    always_comb begin
        rd_w.int_flag = int_flag;
        rd_w.irq_en   = irq_en_q;
        rd_w.gc_ack   = gc_ack_q;
        rd_w.data_ack = data_ack_q;
        rd_w.msel     = msel;
    end
    assign ctl_rd = rd_w;

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cmd_stop |-> (!int_flag && !msel)); // R6
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        irq |-> scl_hold); // R8
endmodule

// File: tb/test_i2c_ctl_seq.sv
`timescale 1ns/1ps
module test_i2c_ctl_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [4:0] wr_data = '0;
    logic bus_busy = 1'b0, xmit_dir = 1'b0, slave_hit = 1'b0;
    logic arb_lost = 1'b0, byte_done = 1'b0;
    logic [1:0] rx_kind = 2'd0;
    logic en_addr7 = 1'b0, en_addr10 = 1'b0;
    logic [4:0] ctl_rd;
    logic cmd_start, cmd_stop, arb_lost_flag, ack_out, scl_hold, irq;

    always #10 clk = ~clk;

    i2c_ctl_seq i_i2c_ctl_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .bus_busy(bus_busy), .xmit_dir(xmit_dir), .slave_hit(slave_hit),
        .arb_lost(arb_lost), .byte_done(byte_done), .rx_kind(rx_kind),
        .en_addr7(en_addr7), .en_addr10(en_addr10), .ctl_rd(ctl_rd),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .arb_lost_flag(arb_lost_flag), .ack_out(ack_out),
        .scl_hold(scl_hold), .irq(irq)
    );

    // observed vector: {start, stop, msel, arb flag, irq, scl hold, ack}
    logic [6:0] obs;
    assign obs = {cmd_start, cmd_stop, ctl_rd[0], arb_lost_flag, irq, scl_hold, ack_out};

    typedef struct {
        string      req;
        int         at;
        logic [6:0] v;
    } item_t;
    item_t q[$];

    int cyc = 0;
    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (q.size() > 0 && q[0].at <= cyc) begin
                item_t it;
                it = q.pop_front();
                compared++;
                if (obs !== it.v) begin
                    mismatched++;
                    $display("FAIL %s: got %b expected %b (cycle %0d)", it.req, obs, it.v, cyc);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_v(input string req, input logic [6:0] v);
        q.push_back('{req, cyc + 1, v});
    endtask

    task automatic wr(input logic [4:0] d, input string req, input logic [6:0] v);
        tick();
        wr_en = 1'b1;
        wr_data = d;
        expect_v(req, v);
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        expect_v("R1 reset", 7'b0000000);

        // R2 idle start
        wr(5'b00001, "R2 start", 7'b1010000);
        bus_busy = 1'b1;
        expect_v("R2 pulse end", 7'b0010000);
        // R7 byte done as master
        tick(); byte_done = 1'b1; expect_v("R7 set", 7'b0010010);
        tick(); byte_done = 1'b0; expect_v("R7 held", 7'b0010010);
        // R8 irq enable
        wr(5'b11001, "R8 irq", 7'b0010110);
        expect_v("R8 irq held", 7'b0010110);
        // R6 stop on clear during interrupt
        wr(5'b10000, "R6 stop", 7'b0100000);
        expect_v("R6 pulse end", 7'b0000000);

        // R3 deferred start
        wr(5'b00001, "R3 wait", 7'b0010000);
        expect_v("R3 wait", 7'b0010000);
        tick(); expect_v("R3 still", 7'b0010000);
        tick(); bus_busy = 1'b0; expect_v("R3 start", 7'b1010000);
        tick(); expect_v("R3 pulse end", 7'b0010000);
        // R5 arbitration loss
        tick(); arb_lost = 1'b1; expect_v("R5 lost", 7'b0001000);
        tick(); arb_lost = 1'b0; expect_v("R5 flag", 7'b0001000);
        tick(); arb_lost = 1'b1; expect_v("R5 idle ignored", 7'b0001000);
        tick(); arb_lost = 1'b0; bus_busy = 1'b1; expect_v("R5 idle", 7'b0001000);

        // R4 cancel by transmitting slave
        wr(5'b00001, "R4 wait clears R5 flag", 7'b0010000);
        slave_hit = 1'b1; xmit_dir = 1'b1;
        expect_v("R4 dropped", 7'b0000000);
        tick(); bus_busy = 1'b0; slave_hit = 1'b0; xmit_dir = 1'b0;
        expect_v("R4 no start", 7'b0000000);
        tick(); expect_v("R4 no start", 7'b0000000);

        // R4 receiving slave keeps request
        tick(); bus_busy = 1'b1; expect_v("R4 busy", 7'b0000000);
        wr(5'b00001, "R4 wait", 7'b0010000);
        slave_hit = 1'b1; expect_v("R4 rx slave", 7'b0010000);
        tick(); byte_done = 1'b1; expect_v("R7 slave set", 7'b0010010);
        tick(); byte_done = 1'b0;
        wr(5'b00001, "R7 sw clear", 7'b0010000);
        slave_hit = 1'b0; bus_busy = 1'b0;
        expect_v("R4 late start", 7'b1010000);
        tick(); expect_v("R4 pulse end", 7'b0010000);

        // R6 clear without interrupt flag
        wr(5'b00000, "R6 no stop", 7'b0000000);
        expect_v("R6 no stop", 7'b0000000);
        // R7 ignored cases
        tick(); byte_done = 1'b1; expect_v("R7 ignored", 7'b0000000);
        tick(); byte_done = 1'b0;
        wr(5'b10000, "R7 sw set ignored", 7'b0000000);
        expect_v("R7 sw set ignored", 7'b0000000);

        // R9 acknowledge selection
        wr(5'b00010, "R9 data ack", 7'b0000001);
        rx_kind = 2'd1; expect_v("R9 addr7 off", 7'b0000000);
        tick(); en_addr7 = 1'b1; expect_v("R9 addr7 on", 7'b0000001);
        tick(); rx_kind = 2'd2; expect_v("R9 addr10 off", 7'b0000000);
        tick(); en_addr10 = 1'b1; expect_v("R9 addr10 on", 7'b0000001);
        tick(); rx_kind = 2'd3; expect_v("R9 gcall off", 7'b0000000);
        wr(5'b00100, "R9 gcall on", 7'b0000001);
        rx_kind = 2'd0; expect_v("R9 data off", 7'b0000000);

        repeat (4) tick();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule